// File: doc/BRIEF.md
# Status Mask Interrupt Controller

This block keeps a 24-bit event status word and a 24-bit enable mask, and from the two it drives a single interrupt pin. Hardware event inputs set status bits. Software clears a status bit by writing 1 to its position. A 0 in the written word leaves that bit as it is. Because of this, a handler can write back exactly the word it read and clear only the events it has seen. Events that arrive between the read and the write are not lost.

Two positions follow their own rules. Bit 0 flags an invalid command and is active low. Bit 5 is the watchdog flag, and a write can clear it only after an energy result has been read. The interrupt pin has four modes: two level modes and two pulse modes. Command decode and the event sources sit outside the block, which sees them only as single-cycle strobes. All the pins are plain control and status signals, so the block has no valid/ready handshake and no back-pressure.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, `status_q` reads 0x000001, `mask_q` reads 0x000000, and with `irq_mode`=00 `irq_pin` is 1.
- R2: A 1 on `evt_set[i]` sets status bit i on the clock edge it is sampled at. This applies to i in {23,22,21,19,17,16,15,14,13,12,11,5,4,3,2}. The bit then stays 1 until it is cleared.
- R3: A status write (`wr_en`=1) clears every listed bit, except 5 and 0, whose `wr_data` bit is 1. Bits written as 0 keep their value.
- R4: When a set and a write-1 clear reach the same bit in the same cycle, the bit ends up 1.
- R5: The reserved positions 20, 18, 10, 9, 8, 7, 6 and 1 always read 0, in both `status_q` and `mask_q`, whatever the events or writes.
- R6: `mask_wr_en`=1 loads `mask_wr_data` into the mask, at the non-reserved positions. A bit whose mask bit is 0 still sets in `status_q` and can be polled there.
- R7: The interrupt condition is true when some position is both active and enabled in the mask. A position is active when its status bit is 1, except bit 0, which is active when it is 0.
- R8: In the level modes the pin follows the condition from the same state. `irq_mode`=00 drives `irq_pin` = NOT condition, and 01 drives `irq_pin` = condition.
- R9: In the pulse modes the pin pulses for one clock in the first cycle in which the condition is true after a cycle in which it was false. Mode 10 idles at 1 and pulses to 0. Mode 11 idles at 0 and pulses to 1.
- R10: `bad_cmd` clears status bit 0 and `port_init` sets it. If both are 1, `bad_cmd` wins. Status writes never change bit 0.
- R11: A write with `wr_data[5]`=1 clears bit 5 only when `energy_rd` was pulsed in an earlier cycle. That pulse counts only if no bit-5 clear write and no watchdog event (`evt_set[5]`) has come after it. Any bit-5 clear write ends this permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | 24 | Hardware event strobes, one per status position |
| bad_cmd | input | 1 | Invalid-command strobe, drives bit 0 low |
| port_init | input | 1 | Port initialization strobe, restores bit 0 |
| energy_rd | input | 1 | Strobe that marks a read of the energy result |
| wr_en | input | 1 | Status write-1-to-clear strobe |
| wr_data | input | 24 | Status clear pattern |
| mask_wr_en | input | 1 | Mask load strobe |
| mask_wr_data | input | 24 | Mask value |
| irq_mode | input | 2 | Pin mode: 00 low level, 01 high level, 10 low pulse, 11 high pulse |
| status_q | output | 24 | Status register |
| mask_q | output | 24 | Mask register |
| irq_pin | output | 1 | Interrupt pin |

## Verification
Directed sequences come first. They show set against clear in one cycle, a bit-5 clear with a prior energy read and without one, `bad_cmd` racing `port_init`, and a pulse-mode rise followed by a held condition. These cases separate the priority rules from plain write-1-clear behaviour. After them, sparse random events, clear writes, mask loads and mode switches run against a bench model, with each bit-5 clear attempt sometimes preceded by an energy read and sometimes not. The random run shows that masked bits still set, that zeros in a write leave bits alone, and that a pulse appears only on a rise of the condition and not while the condition holds.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned STAT_W = 24;
  localparam int unsigned IC_BIT = 0;
  localparam int unsigned WD_BIT = 5;
  // implemented positions: 23,22,21,19,17,16,15,14,13,12,11,5,4,3,2,0
  localparam logic [STAT_W-1:0] VALID_BITS = 24'hEBF83D;
  localparam logic [STAT_W-1:0] RESET_STAT = 24'h000001;
  typedef enum logic [1:0] {
    PIN_LVL_LO  = 2'b00,
    PIN_LVL_HI  = 2'b01,
    PIN_EDGE_LO = 2'b10,
    PIN_EDGE_HI = 2'b11
  } pin_mode_t;
endpackage

// File: rtl/wdt_clear_gate.sv
module wdt_clear_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic energy_rd,
  input  logic clr_try,
  input  logic wd_event,
  output logic clr_ok
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= energy_rd | (armed & ~clr_try & ~wd_event);
  end
  assign clr_ok = armed;
endmodule

// File: rtl/status_bits.sv
module status_bits
  import irq_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_set,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         bad_cmd,
  input  logic         port_init,
  input  logic         wd_clr_ok,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] stat_r;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (!VALID_BITS[i]) begin : g_res
      assign stat_r[i] = 1'b0;
    end else if (i == IC_BIT) begin : g_ic
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= RESET_STAT[i];
        else if (bad_cmd)   q <= 1'b0;
        else if (port_init) q <= 1'b1;
      end
      assign stat_r[i] = q;
    end else begin : g_gen
      logic q;
      logic clr;
      if (i == WD_BIT) begin : g_wd
        assign clr = wr_en & wr_data[i] & wd_clr_ok;
      end else begin : g_norm
        assign clr = wr_en & wr_data[i];
      end
      always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_STAT[i];
        else        q <= evt_set[i] | (q & ~clr);
      end
      assign stat_r[i] = q;
    end
  end

  assign stat_q = stat_r;
endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen
  import irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cond,
  input  pin_mode_t mode,
  output logic      pin
);
  logic cond_d;
  logic rise;
  always_ff @(posedge clk) begin
    if (!rst_n) cond_d <= 1'b0;
    else        cond_d <= cond;
  end
  assign rise = cond & ~cond_d;
  always_comb begin
    unique case (mode)
      PIN_LVL_LO:  pin = ~cond;
      PIN_LVL_HI:  pin = cond;
      PIN_EDGE_LO: pin = ~rise;
      default:     pin = rise;
    endcase
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned W = STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_set,
  input  logic         bad_cmd,
  input  logic         port_init,
  input  logic         energy_rd,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         mask_wr_en,
  input  logic [W-1:0] mask_wr_data,
  input  logic [1:0]   irq_mode,
  output logic [W-1:0] status_q,
  output logic [W-1:0] mask_q,
  output logic         irq_pin
);
  localparam logic [W-1:0] POL = W'(1) << IC_BIT;

  logic [W-1:0] mask_r;
  logic [W-1:0] active;
  logic         wd_ok;
  logic         cond;

  always_ff @(posedge clk) begin
    if (!rst_n)          mask_r <= '0;
    else if (mask_wr_en) mask_r <= mask_wr_data & VALID_BITS;
  end

  wdt_clear_gate u_wdg (
    .clk      (clk),
    .rst_n    (rst_n),
    .energy_rd(energy_rd),
    .clr_try  (wr_en & wr_data[WD_BIT]),
    .wd_event (evt_set[WD_BIT]),
    .clr_ok   (wd_ok)
  );

  status_bits #(.W(W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_set  (evt_set),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .bad_cmd  (bad_cmd),
    .port_init(port_init),
    .wd_clr_ok(wd_ok),
    .stat_q   (status_q)
  );

  assign active = (status_q ^ POL) & VALID_BITS;
  assign cond   = |(active & mask_r);

  irq_pin_gen u_pin (
    .clk  (clk),
    .rst_n(rst_n),
    .cond (cond),
    .mode (pin_mode_t'(irq_mode)),
    .pin  (irq_pin)
  );

  assign mask_q = mask_r;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
  import irq_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [23:0]   evt_set,
  input logic          bad_cmd,
  input logic          port_init,
  input logic          wr_en,
  input logic [23:0]   wr_data,
  input logic [1:0]    irq_mode,
  input logic [23:0]   status_q,
  input logic [23:0]   mask_q,
  input logic          irq_pin
);
  localparam logic [23:0] GEN = VALID_BITS & ~24'h000021;
  localparam logic [23:0] SETTABLE = VALID_BITS & ~24'h000001;

  AST_RESERVED_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~VALID_BITS) == 24'h0); // R5
  AST_RESERVED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~VALID_BITS) == 24'h0); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt_set & SETTABLE)) == $past(evt_set & SETTABLE))); // R4
  AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((status_q & $past(wr_data & GEN & ~evt_set)) == 24'h0)); // R3
  AST_IC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_cmd && !port_init) |=> $stable(status_q[0])); // R10
  AST_LEVEL_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'b01 && (status_q & mask_q & SETTABLE) != 24'h0) |-> irq_pin); // R8
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'b11 && irq_pin) |=> !(irq_mode == 2'b11 && irq_pin)); // R9
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .bad_cmd(bad_cmd),
  .port_init(port_init), .wr_en(wr_en), .wr_data(wr_data),
  .irq_mode(irq_mode), .status_q(status_q), .mask_q(mask_q), .irq_pin(irq_pin)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam logic [23:0] VB = 24'hEBF83D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] evt_set = '0, wr_data = '0, mask_wr_data = '0;
  logic bad_cmd = 0, port_init = 0, energy_rd = 0, wr_en = 0, mask_wr_en = 0;
  logic [1:0] irq_mode = 2'b00;
  logic [23:0] status_q, mask_q;
  logic irq_pin;

  int checks = 0, fails = 0;
  logic [23:0] m_st, m_mk;
  logic m_arm, m_cp, m_pin;

  always #4 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .bad_cmd(bad_cmd),
    .port_init(port_init), .energy_rd(energy_rd), .wr_en(wr_en),
    .wr_data(wr_data), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .irq_mode(irq_mode), .status_q(status_q), .mask_q(mask_q), .irq_pin(irq_pin)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic cond_of(input logic [23:0] st, input logic [23:0] mk);
    return |(((st ^ 24'h1) & VB) & mk);
  endfunction

  // model update for the inputs applied before this edge
  task automatic model_step();
    logic [23:0] n;
    logic c, r;
    n = m_st;
    for (int i = 1; i < 24; i++) begin
      if (VB[i]) begin
        logic clr;
        clr = wr_en && wr_data[i] && (i != 5 || m_arm);
        n[i] = evt_set[i] | (m_st[i] & ~clr);
      end
    end
    if (bad_cmd) n[0] = 1'b0; else if (port_init) n[0] = 1'b1;
    m_arm = energy_rd | (m_arm & ~(wr_en & wr_data[5]) & ~evt_set[5]);
    if (mask_wr_en) m_mk = mask_wr_data & VB;
    m_st = n;
    c = cond_of(m_st, m_mk);
    r = c & ~m_cp;
    m_cp = c;
    case (irq_mode)
      2'b00: m_pin = ~c;
      2'b01: m_pin = c;
      2'b10: m_pin = ~r;
      default: m_pin = r;
    endcase
  endtask

  task automatic step(input string tag);
    @(posedge clk); #1;
    model_step();
    chk({tag, " status"}, status_q, m_st);
    chk("R6 mask", mask_q, m_mk);
    chk({tag, " pin"}, {23'h0, irq_pin}, {23'h0, m_pin});
    evt_set = '0; wr_en = 0; wr_data = '0; mask_wr_en = 0; bad_cmd = 0;
    port_init = 0; energy_rd = 0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_st = 24'h000001; m_mk = '0; m_arm = 0; m_cp = 0; m_pin = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 status", status_q, 24'h000001);
    chk("R1 mask", mask_q, 24'h0);
    chk("R1 pin", {23'h0, irq_pin}, 24'h1);
    // R2 set, R5 reserved ignored
    evt_set = 24'hFFFFFF; step("R2");
    chk("R5 reserved", status_q & ~VB, 24'h0);
    // R3 partial clear; bit 5 stays (no energy read) R11
    wr_en = 1; wr_data = 24'h00F000; step("R3");
    wr_en = 1; wr_data = 24'h000020; step("R11");
    chk("R11 no read", {23'h0, status_q[5]}, 24'h1);
    energy_rd = 1; step("R11");
    wr_en = 1; wr_data = 24'h000020; step("R11");
    chk("R11 after read", {23'h0, status_q[5]}, 24'h0);
    // R4 set beats clear
    wr_en = 1; wr_data = 24'h800000; evt_set = 24'h800000; step("R4");
    chk("R4 bit23", {23'h0, status_q[23]}, 24'h1);
    // R10 invalid command bit
    wr_en = 1; wr_data = 24'hFFFFFF; step("R10");
    chk("R10 write ignored", {23'h0, status_q[0]}, 24'h1);
    bad_cmd = 1; port_init = 1; step("R10");
    chk("R10 bad wins", {23'h0, status_q[0]}, 24'h0);
    // R7 bit0 active low enables the interrupt
    irq_mode = 2'b01; mask_wr_en = 1; mask_wr_data = 24'hFFFFFF; step("R7");
    chk("R7 ic active", {23'h0, irq_pin}, 24'h1);
    port_init = 1; mask_wr_en = 1; mask_wr_data = 24'h000008; step("R8");
    // R9 pulse mode: rise then hold
    irq_mode = 2'b11; step("R9");
    evt_set = 24'h000008; step("R9");
    chk("R9 pulse", {23'h0, irq_pin}, 24'h1);
    step("R9");
    chk("R9 held no pulse", {23'h0, irq_pin}, 24'h0);
    // R6 masked bit still sets
    evt_set = 24'h000010; step("R6");
    chk("R6 masked polled", {23'h0, status_q[4]}, 24'h1);

    // random phase
    void'($urandom(32'h5EED1234));
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 3) == 0) evt_set = 24'(1) << $urandom_range(0, 23);
      if ($urandom_range(0, 4) == 0) begin wr_en = 1; wr_data = 24'($urandom); end
      if ($urandom_range(0, 15) == 0) begin mask_wr_en = 1; mask_wr_data = 24'($urandom); end
      if ($urandom_range(0, 9) == 0) energy_rd = 1;
      if ($urandom_range(0, 40) == 0) bad_cmd = 1;
      if ($urandom_range(0, 40) == 0) port_init = 1;
      if ($urandom_range(0, 60) == 0) irq_mode = 2'($urandom);
      step(irq_mode[1] ? "R9" : "R8");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule